// File: doc/BRIEF.md
# Stepping CPU Clock Generator

This block derives the processor clock of a small 8-bit computer from a 16 MHz reference. In automatic mode a half-period counter toggles the output. The output therefore has an exact 50% duty cycle at every rate on a 1-2-5 ladder, which runs from 1 Hz to 1 MHz. A quadrature rotary encoder moves along the ladder one step per detent. A DIP-switch field jumps straight to the start of a decade. In manual mode each debounced press of a push button yields exactly one clock period, so a CPU can be stepped one cycle at a time. A source select hands the output over to an external 1 MHz crystal clock.

The output is a register clocked by the reference. All mode and source changes are made in the reference domain and take effect only while the output is low. This keeps the output free of short pulses. Reset must be held for at least two reference cycles so that the input synchronisers fill before the encoder and switch values are captured.

The controller has seven states, in three groups:
- **Automatic group.** `ST_AUTO_LO` and `ST_AUTO_HI` alternate when the counter reaches the latched terminal count.
- **Manual group.** `ST_MAN_IDLE` moves to `ST_MAN_HI` on a press. `ST_MAN_HI` moves to `ST_MAN_LO` after one 1 MHz half-period. `ST_MAN_LO` returns to `ST_MAN_IDLE` after another.
- **External group.** `ST_EXT_ARM` waits for the synchronised external clock to be low and then moves to `ST_EXT_RUN`. `ST_EXT_RUN` follows that clock.

A state leaves its group only from `ST_AUTO_LO`, `ST_MAN_IDLE`, `ST_EXT_ARM`, or from `ST_EXT_RUN` with the external clock low. It goes to the entry state of the requested group: `ST_AUTO_LO`, `ST_MAN_IDLE` or `ST_EXT_ARM`.

Top module: `stepclk_gen`

## Requirements
- R1: During reset and after it the output is low. After reset the block runs in automatic mode at ladder step `RESET_STEP` (default 6, 100 Hz). The first rising edge comes one half-period after reset is released.
- R2: In automatic mode, step i gives a rate f = m·10^(i/3) Hz, where m is 1, 2 or 5 for i mod 3 = 0, 1, 2. Both the high phase and the low phase last exactly 16,000,000/(2f) reference cycles.
- R3: A rising edge on encoder channel A steps the index up by one when channel B is low, and down by one when B is high.
- R4: The step index is clamped to 0..18 (1 Hz..1 MHz). Steps beyond either end have no effect.
- R5: A new step takes effect only at the next output edge. No non-external high phase is shorter than 8 reference cycles.
- R6: A change of the 3-bit DIP value d loads step min(3·d, 18). The value present at reset causes no jump.
- R7: In manual mode each debounced press produces one high phase of 8 cycles and then one low phase of 8 cycles. Presses that arrive during that pulse are ignored, and the output otherwise stays low.
- R8: The button counts as pressed only after its synchronised level has differed from the debounced level for `DEB_CYC` consecutive cycles. Shorter pulses are ignored.
- R9: With the external source selected, the output follows the external clock through two synchroniser stages and the output register. Its first high phase is always complete.
- R10: A switch of mode or source occurs only while the output is low. A high phase in progress runs to its full length.
- R11: The source select has priority over manual mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 16 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder channel A (asynchronous) |
| enc_b | input | 1 | Encoder channel B (asynchronous) |
| dip_sel | input | DIP_W | Decade preset switches (asynchronous) |
| step_btn | input | 1 | Single-step push button, high when pressed |
| manual_en | input | 1 | 1 selects manual stepping |
| ext_sel | input | 1 | 1 selects the external clock |
| ext_clk | input | 1 | External 1 MHz crystal clock |
| cpu_clk | output | 1 | Generated CPU clock |

## Verification
Output timing results are measured as phase lengths between consecutive edges, never at absolute times:
- **Encoder and DIP changes.** These reach the step index three cycles after the input changes, but they only become visible at the following output edge. The checks therefore skip one full period before measuring a high and a low phase.
- **Button presses.** A press becomes a pulse about `DEB_CYC`+3 cycles after the button rises. The pulse checks count rising edges and the longest high run inside a window that is wide enough for that delay.
- **External clock.** The external path adds three cycles of delay but keeps phase lengths intact, so it is checked by phase length as well.
- **Reset.** After release, the count of low cycles up to the first rise must equal one half-period.

// File: rtl/stepclk_pkg.sv
package stepclk_pkg;

    // 1-2-5 ladder from 1 Hz to 1 MHz
    localparam int STEPS  = 19;
    localparam int STEP_W = 5;

    typedef enum logic [2:0] {
        ST_AUTO_LO,
        ST_AUTO_HI,
        ST_MAN_IDLE,
        ST_MAN_HI,
        ST_MAN_LO,
        ST_EXT_ARM,
        ST_EXT_RUN
    } clk_state_e;

    typedef enum logic [1:0] {
        GRP_AUTO,
        GRP_MAN,
        GRP_EXT
    } grp_e;

    function automatic grp_e grp_of(clk_state_e s);
        case (s)
            ST_MAN_IDLE, ST_MAN_HI, ST_MAN_LO: return GRP_MAN;
            ST_EXT_ARM, ST_EXT_RUN:            return GRP_EXT;
            default:                           return GRP_AUTO;
        endcase
    endfunction

endpackage

// File: rtl/stepclk_sync.sv
module stepclk_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk) begin
        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/stepclk_rate.sv
module stepclk_rate
    import stepclk_pkg::*;
#(
    parameter int DIP_W      = 3,
    parameter int RESET_STEP = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic [DIP_W-1:0]  dip,
    output logic [STEP_W-1:0] step
);
    localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(STEPS - 1);

    logic              a_q;
    logic [DIP_W-1:0]  dip_q;
    logic [STEP_W-1:0] dip_step;
    int                dip_prod;

    always_comb begin
        dip_prod = int'(dip) * 3;
        dip_step = (dip_prod > STEPS - 1) ? TOP_STEP : STEP_W'(dip_prod);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= enc_a;
            dip_q <= dip;
            step  <= STEP_W'(RESET_STEP);
        end else begin
            a_q   <= enc_a;
            dip_q <= dip;
            if (dip != dip_q) begin
                step <= dip_step;
            end else if (enc_a && !a_q) begin
                if (!enc_b && step < TOP_STEP) begin
                    step <= step + 1'b1;
                end else if (enc_b && step != '0) begin
                    step <= step - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/stepclk_debounce.sv
module stepclk_debounce #(
    parameter int HOLD = 16000
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic press
);
    localparam int CW = $clog2(HOLD + 1);

    logic          stable;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            stable <= 1'b0;
            cnt    <= '0;
            press  <= 1'b0;
        end else begin
            press <= 1'b0;
            if (raw == stable) begin
                cnt <= '0;
            end else if (cnt == CW'(HOLD - 1)) begin
                stable <= raw;
                cnt    <= '0;
                press  <= raw;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/stepclk_gen.sv
module stepclk_gen
    import stepclk_pkg::*;
#(
    parameter int REF_HZ     = 16_000_000,
    parameter int DIP_W      = 3,
    parameter int RESET_STEP = 6,
    parameter int DEB_CYC    = 16000
) (
    input  logic             clk_ref,
    input  logic             rst,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic [DIP_W-1:0] dip_sel,
    input  logic             step_btn,
    input  logic             manual_en,
    input  logic             ext_sel,
    input  logic             ext_clk,
    output logic             cpu_clk
);
    localparam int TC_W   = $clog2(REF_HZ / 2);
    localparam int SYNC_W = DIP_W + 6;

    typedef logic [STEPS-1:0][TC_W-1:0] tc_tab_t;

    function automatic tc_tab_t build_tab();
        tc_tab_t t;
        longint  f;
        for (int i = 0; i < STEPS; i++) begin
            f = (i % 3 == 0) ? 1 : ((i % 3 == 1) ? 2 : 5);
            for (int d = 0; d < i / 3; d++) f = f * 10;
            t[i] = TC_W'(longint'(REF_HZ) / (2 * f) - 1);
        end
        return t;
    endfunction

    localparam tc_tab_t         TC_TAB = build_tab();
    localparam logic [TC_W-1:0] MAN_TC = TC_TAB[STEPS-1];

    logic [SYNC_W-1:0] sync_q;
    logic [DIP_W-1:0]  dip_s;
    logic              a_s, b_s, btn_s, man_s, ext_sel_s, ext_s;

    stepclk_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
        .clk (clk_ref),
        .d   ({ext_clk, ext_sel, manual_en, step_btn, enc_b, enc_a, dip_sel}),
        .q   (sync_q)
    );
    assign {ext_s, ext_sel_s, man_s, btn_s, b_s, a_s, dip_s} = sync_q;

    logic [STEP_W-1:0] step_idx;
    logic              btn_press;

    stepclk_rate #(.DIP_W(DIP_W), .RESET_STEP(RESET_STEP)) u_rate (
        .clk   (clk_ref),
        .rst   (rst),
        .enc_a (a_s),
        .enc_b (b_s),
        .dip   (dip_s),
        .step  (step_idx)
    );

    stepclk_debounce #(.HOLD(DEB_CYC)) u_deb (
        .clk   (clk_ref),
        .rst   (rst),
        .raw   (btn_s),
        .press (btn_press)
    );

    clk_state_e      st, st_nx, entry_st;
    grp_e            want;
    logic [TC_W-1:0] cnt, cnt_nx, tc_q, tc_nx;
    logic            out_nx;

    always_comb begin
        want = ext_sel_s ? GRP_EXT : (man_s ? GRP_MAN : GRP_AUTO);
        unique case (want)
            GRP_MAN: entry_st = ST_MAN_IDLE;
            GRP_EXT: entry_st = ST_EXT_ARM;
            default: entry_st = ST_AUTO_LO;
        endcase
    end

    // next-state logic
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt + 1'b1;
        tc_nx  = tc_q;
        unique case (st)
            ST_AUTO_LO: begin
                if (want != GRP_AUTO) begin
                    st_nx  = entry_st;
                    cnt_nx = '0;
                end else if (cnt == tc_q) begin
                    st_nx  = ST_AUTO_HI;
                    cnt_nx = '0;
                    tc_nx  = TC_TAB[step_idx];
                end
            end
            ST_AUTO_HI: begin
                if (cnt == tc_q) begin
                    st_nx  = ST_AUTO_LO;
                    cnt_nx = '0;
                    tc_nx  = TC_TAB[step_idx];
                end
            end
            ST_MAN_IDLE: begin
                cnt_nx = '0;
                tc_nx  = TC_TAB[step_idx];
                if (want != GRP_MAN) st_nx = entry_st;
                else if (btn_press)  st_nx = ST_MAN_HI;
            end
            ST_MAN_HI: begin
                if (cnt == MAN_TC) begin
                    st_nx  = ST_MAN_LO;
                    cnt_nx = '0;
                end
            end
            ST_MAN_LO: begin
                if (cnt == MAN_TC) begin
                    st_nx  = ST_MAN_IDLE;
                    cnt_nx = '0;
                end
            end
            ST_EXT_ARM: begin
                cnt_nx = '0;
                tc_nx  = TC_TAB[step_idx];
                if (want != GRP_EXT) st_nx = entry_st;
                else if (!ext_s)     st_nx = ST_EXT_RUN;
            end
            ST_EXT_RUN: begin
                cnt_nx = '0;
                tc_nx  = TC_TAB[step_idx];
                if (want != GRP_EXT && !ext_s) st_nx = entry_st;
            end
            default: st_nx = ST_AUTO_LO;
        endcase
    end

    // state register
    always_ff @(posedge clk_ref) begin
        if (rst) begin
            st   <= ST_AUTO_LO;
            cnt  <= '0;
            tc_q <= TC_TAB[RESET_STEP];
        end else begin
            st   <= st_nx;
            cnt  <= cnt_nx;
            tc_q <= tc_nx;
        end
    end

    // output register, driven from the next state
    always_comb begin
        unique case (st_nx)
            ST_AUTO_HI, ST_MAN_HI: out_nx = 1'b1;
            ST_EXT_RUN:            out_nx = ext_s;
            default:               out_nx = 1'b0;
        endcase
    end

    always_ff @(posedge clk_ref) begin
        if (rst) cpu_clk <= 1'b0;
        else     cpu_clk <= out_nx;
    end
endmodule

// File: rtl/stepclk_chk.sv
module stepclk_chk
    import stepclk_pkg::*;
#(
    parameter int TC_W     = 23,
    parameter int MAN_HALF = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_clk,
    input clk_state_e        st,
    input logic              press,
    input logic [TC_W-1:0]   cnt,
    input logic [TC_W-1:0]   tc,
    input logic [STEP_W-1:0] step
);
    logic [TC_W:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)                  hi_run <= '0;
        else if (!cpu_clk)        hi_run <= '0;
        else if (!(&hi_run))      hi_run <= hi_run + 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (st == ST_AUTO_LO || st == ST_AUTO_HI) |-> cnt <= tc); // R2

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        step <= STEP_W'(STEPS - 1)); // R4

    AST_HIGH_FULL: assert property (@(posedge clk) disable iff (rst)
        ($fell(cpu_clk) && $past(st) != ST_EXT_RUN) |-> hi_run >= (TC_W+1)'(MAN_HALF)); // R5

    AST_MAN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ($fell(cpu_clk) && $past(st) == ST_MAN_HI) |-> hi_run == (TC_W+1)'(MAN_HALF)); // R7

    AST_MAN_PRESS: assert property (@(posedge clk) disable iff (rst)
        ($rose(cpu_clk) && st == ST_MAN_HI) |-> $past(press)); // R7

    AST_SWITCH_LOW: assert property (@(posedge clk) disable iff (rst)
        (grp_of(st) != grp_of($past(st))) |-> !cpu_clk); // R10
endmodule

bind stepclk_gen stepclk_chk #(.TC_W(TC_W), .MAN_HALF(int'(MAN_TC) + 1)) u_chk (
    .clk     (clk_ref),
    .rst     (rst),
    .cpu_clk (cpu_clk),
    .st      (st),
    .press   (btn_press),
    .cnt     (cnt),
    .tc      (tc_q),
    .step    (step_idx)
);

// File: tb/stepclk_gen_tb.sv
module stepclk_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enc_a = 1'b0, enc_b = 1'b0;
    logic [2:0] dip_sel = 3'd5;
    logic       step_btn = 1'b0, manual_en = 1'b0, ext_sel = 1'b0;
    logic       ext_clk = 1'b0;
    logic       cpu_clk;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;        // 125 MHz bench clock
    always #64 ext_clk = ~ext_clk; // 16 bench cycles per period

    stepclk_gen #(.RESET_STEP(15), .DEB_CYC(2)) dut_i (
        .clk_ref (clk), .rst (rst), .enc_a (enc_a), .enc_b (enc_b),
        .dip_sel (dip_sel), .step_btn (step_btn), .manual_en (manual_en),
        .ext_sel (ext_sel), .ext_clk (ext_clk), .cpu_clk (cpu_clk)
    );

    // vector table: encoder clicks (signed), new DIP value (-1 none), expected half-period
    localparam int NV = 10;
    localparam int V_CLICK [NV] = '{  1,  2,  1, -3,   -4,  0,   0,  3,  0, -3};
    localparam int V_DIP   [NV] = '{ -1, -1, -1, -1,   -1,  6,   4, -1,  7, -1};
    localparam int V_HALF  [NV] = '{ 40,  8,  8, 80, 1600,  8, 800, 80,  8, 80};
    // rows: R3 up, R3 up to 1 MHz, R4 clamp, R3 down, R3 down to 5 kHz,
    //       R6 dip 6, R6 dip 4, R3 back up, R6 dip 7 clamped, R3 down

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wait_rise();
        @(negedge clk);
        while (cpu_clk !== 1'b0) @(negedge clk);
        while (cpu_clk !== 1'b1) @(negedge clk);
    endtask

    task automatic measure(output int hi, output int lo);
        wait_rise();
        hi = 0;
        while (cpu_clk === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (cpu_clk === 1'b0) begin lo++; @(negedge clk); end
    endtask

    task automatic window(input int n, output int rises, output int hi_max);
        logic prev;
        int   run;
        rises = 0; hi_max = 0; run = 0; prev = cpu_clk;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cpu_clk && !prev) rises++;
            run = cpu_clk ? run + 1 : 0;
            if (run > hi_max) hi_max = run;
            prev = cpu_clk;
        end
    endtask

    task automatic click(input bit up);
        if (up) begin
            enc_a = 1'b1; repeat (4) @(negedge clk);
            enc_b = 1'b1; repeat (4) @(negedge clk);
            enc_a = 1'b0; repeat (4) @(negedge clk);
            enc_b = 1'b0;
        end else begin
            enc_b = 1'b1; repeat (4) @(negedge clk);
            enc_a = 1'b1; repeat (4) @(negedge clk);
            enc_b = 1'b0; repeat (4) @(negedge clk);
            enc_a = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_btn(input int hi_cyc);
        step_btn = 1'b1; repeat (hi_cyc) @(negedge clk);
        step_btn = 1'b0;
    endtask

    initial begin
        int hi, lo, n, rises, hmax;
        repeat (10) @(negedge clk);
        check("R1 output low in reset", int'(cpu_clk), 0);
        rst = 1'b0;
        n = 1; // the release cycle itself is low
        @(negedge clk);
        while (cpu_clk === 1'b0) begin n++; @(negedge clk); end
        check("R1 first low phase after reset", n, 80);

        for (int v = 0; v < NV; v++) begin
            if (V_DIP[v] >= 0) begin
                dip_sel = 3'(V_DIP[v]);
                repeat (6) @(negedge clk);
            end
            for (int c = 0; c < (V_CLICK[v] < 0 ? -V_CLICK[v] : V_CLICK[v]); c++)
                click(V_CLICK[v] > 0);
            wait_rise();
            measure(hi, lo);
            check($sformatf("R2 vector %0d high phase", v), hi, V_HALF[v]);
            check($sformatf("R2 vector %0d low phase", v), lo, V_HALF[v]);
        end

        // R10: source select during a high phase leaves it full length
        wait_rise();
        n = 1;
        repeat (19) begin @(negedge clk); n++; end
        ext_sel = 1'b1;
        @(negedge clk);
        while (cpu_clk === 1'b1) begin n++; @(negedge clk); end
        check("R10 high phase kept whole on switch", n, 80);

        // R9: external clock passed through
        measure(hi, lo);
        check("R9 external high phase", hi, 8);
        check("R9 external low phase", lo, 8);

        // R11: external select wins over manual
        manual_en = 1'b1;
        repeat (8) @(negedge clk);
        measure(hi, lo);
        check("R11 external over manual high", hi, 8);
        check("R11 external over manual low", lo, 8);

        // R7: manual idle keeps output low
        ext_sel = 1'b0;
        window(40, rises, hmax);
        window(100, rises, hmax);
        check("R7 manual idle no edges", rises, 0);

        // R7: one press gives one 8-cycle high phase
        fork
            pulse_btn(12);
            window(80, rises, hmax);
        join
        check("R7 single press rises", rises, 1);
        check("R7 single press high length", hmax, 8);

        // R7: a second press during the pulse is ignored
        fork
            begin pulse_btn(3); repeat (3) @(negedge clk); pulse_btn(3); end
            window(80, rises, hmax);
        join
        check("R7 press during pulse ignored", rises, 1);

        // R8: a one-cycle bounce is not a press
        fork
            pulse_btn(1);
            window(60, rises, hmax);
        join
        check("R8 short glitch ignored", rises, 0);

        // R10/R2: back to automatic at 100 kHz
        manual_en = 1'b0;
        measure(hi, lo);
        check("R10 automatic resumes high", hi, 80);
        check("R10 automatic resumes low", lo, 80);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule